// File: doc/BRIEF.md
# Capability Revocation Bitmap Lookup

This block answers one question for a capability-aware memory system: has the capability stored at a given address been revoked? Revocation state is kept in a bitmap in memory, with one bit for every 8-byte capability granule of RAM. A single bitmap byte therefore covers 64 bytes of RAM. The block turns a 32-bit address into the address of the bitmap byte and the bit position inside it. It fetches that byte over a simple one-byte read port and reports the tested bit as a revoked or not-revoked result.

A client offers an address with a valid/ready handshake. The block first clears the low bits of the address to align it down to the granule. If the aligned address lies below the RAM base, the answer is "not revoked" and no memory read is made. Otherwise the block subtracts the RAM base to get an offset. It reads the byte at the bitmap base plus the offset divided by 64, and tests bit (offset / 8) mod 8 of that byte. The RAM base and the bitmap base are configuration inputs. Integration normally ties them to 0x8000_0000 and 0x8300_0000, and any other values may be used. The result appears with a one-cycle done pulse. The block accepts only one lookup at a time.

Top module: `revmap_lookup`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and mem_rd_en is 0.
- R2: Address bits [2:0] are ignored. Any two addresses that differ only in those bits produce the same bitmap read address and the same tested bit.
- R3: If the aligned address is below cfg_ram_base, done is 1 with revoked 0 in the cycle after acceptance, and mem_rd_en stays 0 for the whole lookup.
- R4: If the aligned address is at or above cfg_ram_base, mem_rd_en is 1 for exactly one cycle, starting the cycle after acceptance. In that cycle mem_rd_addr equals cfg_map_base + ((aligned - cfg_ram_base) >> 6), computed modulo 2^32.
- R5: revoked equals bit ((aligned - cfg_ram_base) >> 3) & 7 of the byte returned on mem_rd_data. Bit 0 is the least significant bit, and 1 means revoked.
- R6: After issuing a read, the block waits for any number of cycles until mem_rd_valid is 1. done rises in the cycle after the cycle in which mem_rd_valid is seen.
- R7: done is a single-cycle pulse. req_ready is 0 from the cycle after acceptance until done has fallen, and is 1 again in the cycle after done.
- R8: A request offered while a lookup is in progress is not accepted. req_ready stays 0, no second read is issued, and the result belongs to the original address.
- R9: An aligned address exactly equal to cfg_ram_base is in range and tests bit 0 of the byte at cfg_map_base. The base inputs take effect for every new lookup, including non-default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | 32 | Address of the capability to test |
| cfg_ram_base | input | 32 | Lowest RAM address covered by the bitmap |
| cfg_map_base | input | 32 | Address of the first bitmap byte |
| mem_rd_en | output | 1 | One-cycle byte read request |
| mem_rd_addr | output | 32 | Byte address of the bitmap read |
| mem_rd_valid | input | 1 | Returned byte is valid |
| mem_rd_data | input | 8 | Returned bitmap byte |
| done | output | 1 | One-cycle result strobe |
| revoked | output | 1 | Result, valid while done is 1 |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-byte granule and 8-bit bitmap bytes. With these, one bitmap byte covers 64 bytes, and every bit index 0 to 7 is reached by random offsets. The bench first drives the usual base pair 0x8000_0000 and 0x8300_0000. It then drives random, unaligned bases, which bring within reach the below-base shortcut, the exact-base boundary and wrap of the bitmap address sum. Read latencies from one to six cycles cover both the immediate and the long wait. Requests offered during a lookup cover the busy case.

// File: rtl/revmap_pkg.sv
package revmap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } revmap_state_e;

endpackage

// File: rtl/revmap_addr_calc.sv
module revmap_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 8,
    parameter int MAP_BYTE_W = 8
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [ADDR_W-1:0]             ram_base_i,
    input  logic [ADDR_W-1:0]             map_base_i,
    output logic                          in_range_o,
    output logic [ADDR_W-1:0]             map_addr_o,
    output logic [$clog2(MAP_BYTE_W)-1:0] bit_idx_o
);
    localparam int GRAN_SH = $clog2(GRAN_BYTES);
    localparam int BIT_W   = $clog2(MAP_BYTE_W);
    localparam int MAP_SH  = GRAN_SH + BIT_W;
    localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'(GRAN_BYTES - 1);

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        aligned    = addr_i & ~GRAN_MASK;
        in_range_o = (aligned >= ram_base_i);
        offset     = aligned - ram_base_i;
        map_addr_o = map_base_i + (offset >> MAP_SH);
        bit_idx_o  = offset[GRAN_SH +: BIT_W];
    end

endmodule

// File: rtl/revmap_bit_pick.sv
module revmap_bit_pick #(
    parameter int MAP_BYTE_W = 8
) (
    input  logic [MAP_BYTE_W-1:0]         byte_i,
    input  logic [$clog2(MAP_BYTE_W)-1:0] idx_i,
    output logic                          bit_o
);
    localparam int BIT_W = $clog2(MAP_BYTE_W);

    logic [MAP_BYTE_W-1:0] hit;

    for (genvar i = 0; i < MAP_BYTE_W; i++) begin : g_lane
        assign hit[i] = byte_i[i] & (idx_i == BIT_W'(i));
    end

    assign bit_o = |hit;

endmodule

// File: rtl/revmap_lookup.sv
module revmap_lookup
    import revmap_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 8,
    parameter int MAP_BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [ADDR_W-1:0]     cfg_ram_base,
    input  logic [ADDR_W-1:0]     cfg_map_base,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [MAP_BYTE_W-1:0] mem_rd_data,
    output logic                  done,
    output logic                  revoked
);
    localparam int BIT_W = $clog2(MAP_BYTE_W);

    typedef struct packed {
        revmap_state_e     state;
        logic              rd_en;
        logic [ADDR_W-1:0] rd_addr;
        logic [BIT_W-1:0]  bit_idx;
        logic              done;
        logic              revoked;
    } revmap_regs_t;

    revmap_regs_t cur_q, nxt_d;

    logic              in_range_c;
    logic [ADDR_W-1:0] map_addr_c;
    logic [BIT_W-1:0]  bit_idx_c;
    logic              picked_c;

    revmap_addr_calc #(
        .ADDR_W    (ADDR_W),
        .GRAN_BYTES(GRAN_BYTES),
        .MAP_BYTE_W(MAP_BYTE_W)
    ) u_addr (
        .addr_i    (req_addr),
        .ram_base_i(cfg_ram_base),
        .map_base_i(cfg_map_base),
        .in_range_o(in_range_c),
        .map_addr_o(map_addr_c),
        .bit_idx_o (bit_idx_c)
    );

    revmap_bit_pick #(
        .MAP_BYTE_W(MAP_BYTE_W)
    ) u_pick (
        .byte_i(mem_rd_data),
        .idx_i (cur_q.bit_idx),
        .bit_o (picked_c)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.rd_en = 1'b0;
        nxt_d.done  = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (in_range_c) begin
                        nxt_d.rd_en   = 1'b1;
                        nxt_d.rd_addr = map_addr_c;
                        nxt_d.bit_idx = bit_idx_c;
                        nxt_d.state   = ST_WAIT;
                    end else begin
                        nxt_d.revoked = 1'b0;
                        nxt_d.done    = 1'b1;
                        nxt_d.state   = ST_RESP;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    nxt_d.revoked = picked_c;
                    nxt_d.done    = 1'b1;
                    nxt_d.state   = ST_RESP;
                end
            end
            ST_RESP: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, rd_en: 1'b0, rd_addr: '0,
                       bit_idx: '0, done: 1'b0, revoked: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready   = (cur_q.state == ST_IDLE);
    assign mem_rd_en   = cur_q.rd_en;
    assign mem_rd_addr = cur_q.rd_addr;
    assign done        = cur_q.done;
    assign revoked     = cur_q.revoked;

endmodule

// File: rtl/revmap_lookup_chk.sv
module revmap_lookup_chk #(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 8,
    parameter int MAP_BYTE_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [ADDR_W-1:0]     cfg_ram_base,
    input logic [ADDR_W-1:0]     cfg_map_base,
    input logic                  mem_rd_en,
    input logic [ADDR_W-1:0]     mem_rd_addr,
    input logic                  mem_rd_valid,
    input logic [MAP_BYTE_W-1:0] mem_rd_data,
    input logic                  done,
    input logic                  revoked
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(GRAN_BYTES - 1);

    logic accept_c;
    logic below_c;

    assign accept_c = req_valid && req_ready;
    assign below_c  = ((req_addr & ~LOW_MASK) < cfg_ram_base);

    assert_below_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_c && below_c) |=> (done && !revoked && !mem_rd_en));

    assert_read_issued_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_c && !below_c) |=> (mem_rd_en && !done));

    assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || done) |-> !req_ready);

    assert_no_read_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_en);

endmodule

bind revmap_lookup revmap_lookup_chk #(
    .ADDR_W    (ADDR_W),
    .GRAN_BYTES(GRAN_BYTES),
    .MAP_BYTE_W(MAP_BYTE_W)
) u_chk (.*);

// File: tb/revmap_lookup_bench.sv
`timescale 1ns/1ps
module revmap_lookup_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] cfg_ram_base = 32'h8000_0000;
    logic [31:0] cfg_map_base = 32'h8300_0000;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [7:0]  mem_rd_data = '0;
    logic        done;
    logic        revoked;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    revmap_lookup u_revmap_lookup (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .cfg_ram_base(cfg_ram_base),
        .cfg_map_base(cfg_map_base),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_data (mem_rd_data),
        .done        (done),
        .revoked     (revoked)
    );

    function automatic logic [31:0] f_aligned(input logic [31:0] a);
        return {a[31:3], 3'b000};
    endfunction

    function automatic bit f_in_range(input logic [31:0] a);
        return f_aligned(a) >= cfg_ram_base;
    endfunction

    function automatic logic [31:0] f_map_addr(input logic [31:0] a);
        logic [31:0] off;
        off = f_aligned(a) - cfg_ram_base;
        return cfg_map_base + (off / 64);
    endfunction

    function automatic int f_bit(input logic [31:0] a);
        logic [31:0] off;
        off = f_aligned(a) - cfg_ram_base;
        return int'((off / 8) % 8);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    // One complete lookup; lat is the read latency in cycles (>= 1).
    task automatic lookup(input logic [31:0] a, input int lat,
                          input logic [7:0] data_v, input bit poke);
        bit          exp_rev;
        logic [31:0] exp_addr;
        exp_addr = f_map_addr(a);
        exp_rev  = f_in_range(a) ? data_v[f_bit(a)] : 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!f_in_range(a)) begin
            chk(done == 1'b1, "R3 done after below-base accept", 32'(done), 32'd1);
            chk(revoked == 1'b0, "R3 below base not revoked", 32'(revoked), 32'd0);
            chk(mem_rd_en == 1'b0, "R3 no read below base", 32'(mem_rd_en), 32'd0);
        end else begin
            chk(mem_rd_en == 1'b1, "R4 read issued", 32'(mem_rd_en), 32'd1);
            chk(mem_rd_addr == exp_addr, "R4 read address", mem_rd_addr, exp_addr);
            chk(req_ready == 1'b0, "R7 busy after accept", 32'(req_ready), 32'd0);
            if (poke) begin
                req_valid = 1'b1;
                req_addr  = a ^ 32'h0000_0140;
            end
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                chk(mem_rd_en == 1'b0, "R8 no second read while waiting",
                    32'(mem_rd_en), 32'd0);
                chk(req_ready == 1'b0, "R8 not ready while waiting",
                    32'(req_ready), 32'd0);
                chk(done == 1'b0, "R6 no done before data", 32'(done), 32'd0);
            end
            req_valid    = 1'b0;
            mem_rd_valid = 1'b1;
            mem_rd_data  = data_v;
            @(negedge clk);
            mem_rd_valid = 1'b0;
            mem_rd_data  = $urandom();
            chk(done == 1'b1, "R6 done after data", 32'(done), 32'd1);
            chk(revoked == exp_rev, "R5 tested bit", 32'(revoked), 32'(exp_rev));
            chk(req_ready == 1'b0, "R7 not ready during done", 32'(req_ready), 32'd0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R7 done is one cycle", 32'(done), 32'd0);
        chk(req_ready == 1'b1, "R7 ready after done", 32'(req_ready), 32'd1);
        chk(mem_rd_en == 1'b0, "R8 no extra read", 32'(mem_rd_en), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        summary();
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        chk(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
        chk(mem_rd_en == 1'b0, "R1 reset read", 32'(mem_rd_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_rd_en == 1'b0, "R1 idle after reset",
            32'(req_ready), 32'd1);

        // R9: exact base and one below it, default bases
        lookup(32'h8000_0000, 1, 8'h01, 1'b0);
        lookup(32'h8000_0007, 2, 8'hFE, 1'b0);
        lookup(32'h7FFF_FFFF, 1, 8'hFF, 1'b0);
        lookup(32'h0000_0000, 1, 8'hFF, 1'b0);
        // R2: low bits ignored, same byte and bit
        lookup(32'h8000_0478, 3, 8'h80, 1'b0);
        lookup(32'h8000_047F, 1, 8'h80, 1'b0);
        lookup(32'h8000_047C, 2, 8'h7F, 1'b0);
        // R6 long wait and R8 request during busy
        lookup(32'h8123_4568, 6, 8'hA5, 1'b1);
        lookup(32'hFFFF_FFFF, 4, 8'h80, 1'b1);

        for (int n = 0; n < 300; n++) begin
            if (n == 150) begin
                // R9: non-default, unaligned bases
                cfg_ram_base = 32'h0001_2345;
                cfg_map_base = 32'hFFFF_FFF0;
                lookup(32'h0001_2345, 1, 8'h01, 1'b0);
                lookup(32'h0001_2347, 1, 8'h01, 1'b0);
                lookup(32'h0001_2340, 1, 8'hFF, 1'b0);
            end
            if (n > 150 && ($urandom() % 8) == 0) begin
                cfg_ram_base = $urandom();
                cfg_map_base = $urandom();
            end
            case ($urandom() % 4)
                0:       a = cfg_ram_base - 32'($urandom() % 64);
                1:       a = cfg_ram_base + 32'($urandom() % 1024);
                default: a = $urandom();
            endcase
            lookup(a, 1 + int'($urandom() % 6), 8'($urandom()),
                   ($urandom() % 4) == 0);
        end
        summary();
    end

endmodule